// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a classic 8-bit controller's external bus: an address-latch pulse that tells outside logic when the multiplexed low address byte is valid, and an active-low program-fetch strobe that reads external code memory. It runs from the system clock and advances only when the oscillator tick input is high. It is told where it stands in the machine cycle by a phase count supplied by the sequencer. Every output is registered.

A machine cycle is split into two equal halves. The address-latch pulse fires once in each half, which gives two pulses per cycle at one sixth of the oscillator rate. The fetch strobe also fires once in each half, but only while code is being fetched from outside. During an external data-memory access cycle, the second address-latch pulse and both fetch strobes are dropped. A disable bit silences the address latch outside data-move and code-table cycles, and the pin is then handed to a weak pull-up. The disable bit does nothing while code is executing from external memory.

Top module: `bus_strobe_gen`

## Requirements
- R1: While rst_n is low, ale is 0, psen_n is 1 and ale_pu is 0.
- R2: All three outputs change only on a rising clk edge at which osc_tick is 1; at any other edge they hold their values.
- R3: With no disable in force and no data access, an edge with osc_tick sets ale to 1 exactly when phase is 0, 1, 6 or 7 (two 2-tick pulses per 12-tick machine cycle) and to 0 otherwise.
- R4: When xdata_cyc is 1, ale stays 0 for phases 6 to 11, while the phase 0 and 1 pulse still occurs.
- R5: With ext_exec 1 and xdata_cyc 0, an edge with osc_tick drives psen_n to 0 exactly when phase is 3, 4, 5, 9, 10 or 11, and to 1 otherwise.
- R6: When xdata_cyc is 1, psen_n is 1 for the whole machine cycle.
- R7: When ext_exec is 0, psen_n is 1 for every phase.
- R8: When ale_off is 1, ext_exec is 0, and both xdata_cyc and movc_cyc are 0, ale is 0 and ale_pu is 1. ale_pu is never 1 while ale is 1.
- R9: When ale_off is 1, ext_exec is 0, and either xdata_cyc or movc_cyc is 1, ale pulses as in R3 and R4, and ale_pu is 0.
- R10: When ext_exec is 1, ale_off has no effect: ale follows R3 and R4, and ale_pu is 0.
- R11: A phase value of 12 to 15 is outside the cycle. It gives ale 0 and psen_n 1, and ale_pu still follows R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | Oscillator-period enable; outputs update only when it is high |
| phase | input | 4 | Position within the 12-tick machine cycle |
| xdata_cyc | input | 1 | Current machine cycle is an external data-memory access |
| movc_cyc | input | 1 | Current machine cycle is a code-table read |
| ext_exec | input | 1 | Code is being fetched from external program memory |
| ale_off | input | 1 | Address-latch disable bit |
| ale | output | 1 | Address-latch enable strobe, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| ale_pu | output | 1 | Weak pull-up enable for the address-latch pin (pin not driven) |

## Verification
The bench builds the block with its default parameters: a 12-tick cycle, a 2-tick latch window at the start of each half, and a 3-tick fetch window at the end of each half. With these values the 4-bit phase input can take the four unused codes 12 to 15, so the out-of-cycle handling of R11 is driven as well as every in-cycle position. Random phases, flag combinations and dropped ticks cover every pairing of disable bit, external execution and access type. This brings the override interactions of R8 to R10 and the hold rule of R2 within reach at every phase.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic ale_pu;
    } strobe_t;

    localparam strobe_t STROBE_RESET = '{ale: 1'b0, psen_n: 1'b1, ale_pu: 1'b0};

endpackage

// File: rtl/bsg_phase_decode.sv
module bsg_phase_decode #(
    parameter int CYC_LEN  = 12,
    parameter int PH_W     = 4,
    parameter int ALE_OFS  = 0,
    parameter int ALE_W    = 2,
    parameter int PSEN_OFS = 3,
    parameter int PSEN_W   = 3
) (
    input  logic [PH_W-1:0] phase,
    output logic            in_cycle,
    output logic            late_half,
    output logic            ale_win,
    output logic            psen_win
);
    localparam int HALF = CYC_LEN / 2;

    int ph_i;
    int pos_i;

    always_comb begin
        ph_i      = int'(phase);
        in_cycle  = (ph_i < CYC_LEN);
        late_half = (ph_i >= HALF);
        pos_i     = late_half ? (ph_i - HALF) : ph_i;
        ale_win   = in_cycle && (pos_i >= ALE_OFS) && (pos_i < ALE_OFS + ALE_W);
        psen_win  = in_cycle && (pos_i >= PSEN_OFS) && (pos_i < PSEN_OFS + PSEN_W);
    end

endmodule

// File: rtl/bsg_ale_gate.sv
module bsg_ale_gate (
    input  logic ale_win,
    input  logic late_half,
    input  logic xdata_cyc,
    input  logic movc_cyc,
    input  logic ext_exec,
    input  logic ale_off,
    output logic ale_nxt,
    output logic pu_nxt
);
    logic off_eff;
    logic bus_access;
    logic parked;
    logic skip_slot;

    always_comb begin
        off_eff    = ale_off && !ext_exec;
        bus_access = xdata_cyc || movc_cyc;
        parked     = off_eff && !bus_access;
        skip_slot  = xdata_cyc && late_half;
        ale_nxt    = ale_win && !parked && !skip_slot;
        pu_nxt     = parked;
    end

endmodule

// File: rtl/bsg_psen_gate.sv
module bsg_psen_gate (
    input  logic psen_win,
    input  logic ext_exec,
    input  logic xdata_cyc,
    output logic psen_n_nxt
);
    always_comb begin
        psen_n_nxt = !(psen_win && ext_exec && !xdata_cyc);
    end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_strobe_pkg::*;
#(
    parameter int CYC_LEN  = 12,
    parameter int PH_W     = 4,
    parameter int ALE_OFS  = 0,
    parameter int ALE_W    = 2,
    parameter int PSEN_OFS = 3,
    parameter int PSEN_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            osc_tick,
    input  logic [PH_W-1:0] phase,
    input  logic            xdata_cyc,
    input  logic            movc_cyc,
    input  logic            ext_exec,
    input  logic            ale_off,
    output logic            ale,
    output logic            psen_n,
    output logic            ale_pu
);
    logic in_cycle;
    logic late_half;
    logic ale_win;
    logic psen_win;
    logic ale_nxt;
    logic pu_nxt;
    logic psen_n_nxt;

    strobe_t st_d;
    strobe_t st_q;

    bsg_phase_decode #(
        .CYC_LEN (CYC_LEN),
        .PH_W    (PH_W),
        .ALE_OFS (ALE_OFS),
        .ALE_W   (ALE_W),
        .PSEN_OFS(PSEN_OFS),
        .PSEN_W  (PSEN_W)
    ) u_decode (
        .phase    (phase),
        .in_cycle (in_cycle),
        .late_half(late_half),
        .ale_win  (ale_win),
        .psen_win (psen_win)
    );

    bsg_ale_gate u_ale (
        .ale_win  (ale_win),
        .late_half(late_half),
        .xdata_cyc(xdata_cyc),
        .movc_cyc (movc_cyc),
        .ext_exec (ext_exec),
        .ale_off  (ale_off),
        .ale_nxt  (ale_nxt),
        .pu_nxt   (pu_nxt)
    );

    bsg_psen_gate u_psen (
        .psen_win  (psen_win),
        .ext_exec  (ext_exec),
        .xdata_cyc (xdata_cyc),
        .psen_n_nxt(psen_n_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (osc_tick) begin
            st_d.ale    = ale_nxt;
            st_d.psen_n = psen_n_nxt;
            st_d.ale_pu = pu_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STROBE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ale    = st_q.ale;
    assign psen_n = st_q.psen_n;
    assign ale_pu = st_q.ale_pu;

    logic unused_ok;
    assign unused_ok = in_cycle;

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
    parameter int CYC_LEN = 12,
    parameter int PH_W    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            osc_tick,
    input logic [PH_W-1:0] phase,
    input logic            xdata_cyc,
    input logic            movc_cyc,
    input logic            ext_exec,
    input logic            ale_off,
    input logic            ale,
    input logic            psen_n,
    input logic            ale_pu
);
    localparam int HALF = CYC_LEN / 2;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> ($stable(ale) && $stable(psen_n) && $stable(ale_pu)));

    a_r4_skip_late_ale: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && xdata_cyc && int'(phase) >= HALF) |=> !ale);

    a_r6_xdata_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && xdata_cyc) |=> psen_n);

    a_r7_internal_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && !ext_exec) |=> psen_n);

    a_r8_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && ale_off && !ext_exec && !xdata_cyc && !movc_cyc) |=> (!ale && ale_pu));

    a_r8_pu_excl: assert property (@(posedge clk) disable iff (!rst_n)
        ale_pu |-> !ale);

    a_r10_exec_override: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && ext_exec) |=> !ale_pu);

    a_r11_out_of_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_tick && int'(phase) >= CYC_LEN) |=> (!ale && psen_n));

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(
    .CYC_LEN(CYC_LEN),
    .PH_W   (PH_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .phase    (phase),
    .xdata_cyc(xdata_cyc),
    .movc_cyc (movc_cyc),
    .ext_exec (ext_exec),
    .ale_off  (ale_off),
    .ale      (ale),
    .psen_n   (psen_n),
    .ale_pu   (ale_pu)
);

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;

    localparam time CLK_P = 8ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic [3:0] phase = '0;
    logic       xdata_cyc = 1'b0;
    logic       movc_cyc = 1'b0;
    logic       ext_exec = 1'b0;
    logic       ale_off = 1'b0;
    logic       ale;
    logic       psen_n;
    logic       ale_pu;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic exp_ale = 1'b0;
    logic exp_psn = 1'b1;
    logic exp_pu  = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    bus_strobe_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .phase    (phase),
        .xdata_cyc(xdata_cyc),
        .movc_cyc (movc_cyc),
        .ext_exec (ext_exec),
        .ale_off  (ale_off),
        .ale      (ale),
        .psen_n   (psen_n),
        .ale_pu   (ale_pu)
    );

    function automatic logic ref_ale(int ph, logic xd, logic mc, logic ex, logic off);
        logic parked;
        parked = off && !ex && !xd && !mc;
        if (ph >= 12 || parked) return 1'b0;
        if (xd && ph >= 6) return 1'b0;
        return (ph % 6) < 2;
    endfunction

    function automatic logic ref_psn(int ph, logic xd, logic ex);
        if (ph >= 12 || !ex || xd) return 1'b1;
        return !((ph % 6) >= 3);
    endfunction

    function automatic logic ref_pu(logic xd, logic mc, logic ex, logic off);
        return off && !ex && !xd && !mc;
    endfunction

    function automatic string ale_tag(logic tk, int ph, logic xd, logic mc, logic ex, logic off);
        if (!tk) return "R2";
        if (ph >= 12) return "R11";
        if (off && !ex && !xd && !mc) return "R8";
        if (off && ex) return "R10";
        if (off) return "R9";
        if (xd) return "R4";
        return "R3";
    endfunction

    function automatic string psn_tag(logic tk, int ph, logic xd, logic ex);
        if (!tk) return "R2";
        if (ph >= 12) return "R11";
        if (!ex) return "R7";
        if (xd) return "R6";
        return "R5";
    endfunction

    task automatic check_bit(string tag, string nm, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, nm, act, exp);
        end
    endtask

    // Drive at negedge, one posedge registers, check at the next negedge.
    task automatic step(logic tk, int ph, logic xd, logic mc, logic ex, logic off);
        string ta;
        string tp;
        string tu;
        osc_tick  = tk;
        phase     = 4'(ph);
        xdata_cyc = xd;
        movc_cyc  = mc;
        ext_exec  = ex;
        ale_off   = off;
        ta = ale_tag(tk, ph, xd, mc, ex, off);
        tp = psn_tag(tk, ph, xd, ex);
        tu = tk ? ((ex && off) ? "R10" : ((off && (xd || mc)) ? "R9" : "R8")) : "R2";
        if (tk) begin
            exp_ale = ref_ale(ph, xd, mc, ex, off);
            exp_psn = ref_psn(ph, xd, ex);
            exp_pu  = ref_pu(xd, mc, ex, off);
        end
        @(negedge clk);
        check_bit(ta, "ale", ale, exp_ale);
        check_bit(tp, "psen_n", psen_n, exp_psn);
        check_bit(tu, "ale_pu", ale_pu, exp_pu);
    endtask

    task automatic sweep(logic xd, logic mc, logic ex, logic off);
        for (int p = 0; p < 12; p++) step(1'b1, p, xd, mc, ex, off);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state, also with active inputs
        osc_tick = 1'b1; ext_exec = 1'b1; phase = 4'd0;
        repeat (3) @(negedge clk);
        check_bit("R1", "ale", ale, 1'b0);
        check_bit("R1", "psen_n", psen_n, 1'b1);
        check_bit("R1", "ale_pu", ale_pu, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed sweeps: R3, R5, R4, R6, R7, R8, R9, R10
        sweep(1'b0, 1'b0, 1'b0, 1'b0);
        sweep(1'b0, 1'b0, 1'b1, 1'b0);
        sweep(1'b1, 1'b0, 1'b1, 1'b0);
        sweep(1'b1, 1'b0, 1'b0, 1'b0);
        sweep(1'b0, 1'b0, 1'b0, 1'b1);
        sweep(1'b0, 1'b1, 1'b0, 1'b1);
        sweep(1'b1, 1'b0, 1'b0, 1'b1);
        sweep(1'b0, 1'b0, 1'b1, 1'b1);
        // R11: unused phase codes
        for (int p = 12; p < 16; p++) step(1'b1, p, 1'b0, 1'b0, 1'b1, 1'b0);
        for (int p = 12; p < 16; p++) step(1'b1, p, 1'b0, 1'b0, 1'b0, 1'b1);
        // R2: hold with tick low across a pulse boundary
        step(1'b1, 0, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 3, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 5, 1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 4, 1'b0, 1'b0, 1'b1, 1'b0);
        step(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1);

        // Constrained random
        for (int i = 0; i < 3000; i++) begin
            logic tk;
            tk = ($urandom % 4) != 0;
            step(tk, int'($urandom % 16), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule